// File: doc/BRIEF.md
# Recirculating Longest-Prefix-Match Lookup Engine

This engine resolves the longest-prefix match of 32-bit IPv4 destination addresses. The routing table is a three-level sparse tree that sits in a single external lookup memory. The first level is 16 bits wide and each of the next two levels is 8 bits wide. Every lookup enters through one access loop. It issues its first memory read, and while that read is outstanding it parks its unused address bits, its sequence tag and its level in a recirculation FIFO. When the memory answers, the lookup does one of two things. If the entry is a leaf, the lookup finishes. Otherwise it goes round the loop once more, with the next address byte added to the entry's pointer. Several lookups are in flight at the same time and they share the one memory port.

The memory port has a fixed latency of `LAT` clock edges and always accepts a request. For a request presented on the edge t, the engine takes the answer from `mem_rsp_data` during the cycle that ends on edge t+`LAT`.

A lookup can finish before an older one. For that reason each accepted address reserves a slot in a reorder buffer, and results leave strictly in arrival order.

The input and output are valid/ready streams. An address is taken on an edge where `in_valid` and `in_ready` are both high. `in_ready` falls in three cases:
- the reorder buffer has no free slot;
- the memory port is taken by a recirculating lookup;
- `clear` is high.

A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head result stays on the port unchanged.

`clear` is synchronous. It discards every lookup in progress, and any memory answers still on their way are ignored.

Top module: `lpm_circ_engine`

## Requirements
- R1: An accepted address issues its first read in the same cycle, at address in_addr[31:16] zero-extended to MEM_AW bits.
- R2: A table entry is MEM_AW+1 bits. Bit MEM_AW is the leaf flag, and bits MEM_AW-1:0 hold the result (leaf) or the base pointer (non-leaf). A leaf's field is delivered unchanged as out_result.
- R3: A non-leaf answer to the first read issues the second read in the answer cycle, at pointer + in_addr[15:8]. A non-leaf answer to the second read issues the third read at pointer + in_addr[7:0].
- R4: The answer to the third read is taken as a leaf whatever its flag bit.
- R5: In a cycle where a non-leaf answer issues a follow-up read, in_ready is low, so recirculation has the port.
- R6: In a cycle where a leaf answer arrives, a new address can be accepted and issue its first read.
- R7: Results leave in the order in which their addresses were accepted, even when a younger lookup finishes first.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_result stays stable.
- R9: At most ROB_DEPTH lookups are held between acceptance and delivery. With ROB_DEPTH outstanding, in_ready is low.
- R10: clear empties all state. In the next cycle out_valid is low, answers to reads issued before the clear produce no result, and later lookups resolve correctly.
- R11: After reset, in_ready is high and out_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of all lookups |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | 32 | Destination address |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_result | output | MEM_AW | Leaf value of the match |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | MEM_AW | Memory read address |
| mem_rsp_data | input | MEM_AW+1 | Entry read LAT edges after the request |

## Verification
The bench builds the engine with LAT=5 and ROB_DEPTH=4, keeping MEM_AW=18. The five-edge latency keeps several lookups in the loop at once, so a three-read lookup is overtaken by single-read lookups that entered after it. Four reorder slots let a held output fill the buffer after only a few addresses, which brings the entry stall within reach. A third-level entry with its leaf flag cleared exercises the forced leaf, and a clear issued while reads are outstanding shows that stale answers are dropped.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LV_FIRST = 2'd0;
  localparam logic [LVL_W-1:0] LV_LAST  = 2'd2;
  localparam int RES_BITS = 16;  // residual address bits carried in the loop
endpackage

// File: rtl/lpm_recirc_fifo.sv
module lpm_recirc_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_p, rd_p;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= wdata;
  end

  // pop happens before push in a cycle, so a full FIFO accepts push+pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else if (clear) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) wr_p <= step(wr_p);
      if (pop)  rd_p <= step(rd_p);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = slots[rd_p];
endmodule

// File: rtl/lpm_issue_track.sv
module lpm_issue_track #(
  parameter int LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic issue,
  output logic rsp_here
);
  generate
    if (LAT == 1) begin : g_single
      logic pend;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend <= 1'b0;
        else if (clear) pend <= 1'b0;
        else            pend <= issue;
      end
      assign rsp_here = pend;
    end else begin : g_chain
      logic [LAT-1:0] pend;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend <= '0;
        else if (clear) pend <= '0;
        else            pend <= {pend[LAT-2:0], issue};
      end
      assign rsp_here = pend[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/lpm_reorder_buf.sv
module lpm_reorder_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       alloc,
  output logic [$clog2(DEPTH)-1:0]   alloc_tag,
  output logic                       full,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_tag,
  input  logic [DW-1:0]              wr_data,
  output logic                       out_valid,
  output logic [DW-1:0]              out_data,
  input  logic                       out_ready
);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0]    vals [DEPTH];
  logic [DEPTH-1:0] done;
  logic [TW-1:0]    head, tail;
  logic [CW-1:0]    used;
  logic             take;

  assign take      = out_valid && out_ready;
  assign out_valid = done[head];
  assign out_data  = vals[head];
  assign alloc_tag = tail;
  assign full      = (used == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) vals[wr_tag] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      used <= '0;
      done <= '0;
    end else if (clear) begin
      head <= '0;
      tail <= '0;
      used <= '0;
      done <= '0;
    end else begin
      if (alloc) tail <= tail + 1'b1;
      if (take)  head <= head + 1'b1;
      used <= used + CW'(alloc) - CW'(take);
      if (wr_en) done[wr_tag] <= 1'b1;
      if (take)  done[head]   <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_circ_engine.sv
module lpm_circ_engine #(
  parameter int MEM_AW    = 18,
  parameter int LAT       = 6,
  parameter int ROB_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MEM_AW-1:0] out_result,
  output logic              mem_req_valid,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic [MEM_AW:0]   mem_rsp_data
);
  import lpm_pkg::*;

  localparam int TW  = $clog2(ROB_DEPTH);
  localparam int FW  = RES_BITS + TW + LVL_W;
  localparam int FCW = $clog2(LAT + 1);

  logic              rsp_here, rsp_leaf, recirc, finish, enter, rob_full;
  logic [TW-1:0]     new_tag, head_tag;
  logic [FW-1:0]     push_word, head_word;
  logic [RES_BITS-1:0] head_res;
  logic [LVL_W-1:0]  head_lvl;
  logic [MEM_AW-1:0] rsp_field;
  logic [FCW-1:0]    fifo_cnt;

  assign {head_res, head_tag, head_lvl} = head_word;
  assign rsp_field = mem_rsp_data[MEM_AW-1:0];

  // the deepest level always ends the walk
  assign rsp_leaf = mem_rsp_data[MEM_AW] || (head_lvl == LV_LAST);
  assign recirc   = rsp_here && !rsp_leaf && !clear;
  assign finish   = rsp_here &&  rsp_leaf && !clear;

  assign in_ready = !clear && !rob_full && !recirc;
  assign enter    = in_valid && in_ready;

  assign mem_req_valid = recirc || enter;
  assign mem_req_addr  = recirc ? rsp_field + MEM_AW'(head_res[RES_BITS-1 -: 8])
                                : MEM_AW'(in_addr[31:16]);

  assign push_word = recirc ? {head_res << 8, head_tag, head_lvl + 1'b1}
                            : {in_addr[RES_BITS-1:0], new_tag, LV_FIRST};

  lpm_issue_track #(.LAT(LAT)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .issue(mem_req_valid), .rsp_here(rsp_here)
  );

  lpm_recirc_fifo #(.W(FW), .DEPTH(LAT)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push(mem_req_valid), .wdata(push_word),
    .pop(rsp_here), .rdata(head_word), .count(fifo_cnt)
  );

  lpm_reorder_buf #(.DEPTH(ROB_DEPTH), .DW(MEM_AW)) u_rob (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .alloc(enter), .alloc_tag(new_tag), .full(rob_full),
    .wr_en(finish), .wr_tag(head_tag), .wr_data(rsp_field),
    .out_valid(out_valid), .out_data(out_result), .out_ready(out_ready)
  );
endmodule

// File: rtl/lpm_circ_engine_chk.sv
module lpm_circ_engine_chk #(
  parameter int MEM_AW = 18,
  parameter int LAT    = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         clear,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic [31:0]                  in_addr,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [MEM_AW-1:0]            out_result,
  input logic                         mem_req_valid,
  input logic [MEM_AW-1:0]            mem_req_addr,
  input logic                         rsp_here,
  input logic                         rsp_leaf,
  input logic                         rob_full,
  input logic [$clog2(LAT+1)-1:0]     fifo_cnt
);
  a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr == MEM_AW'(in_addr[31:16])));

  a_r5_recirc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_here && !rsp_leaf && !clear) |-> (!in_ready && mem_req_valid));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_result)));

  a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !in_ready);

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !out_valid);

  a_r3_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= LAT);
endmodule

bind lpm_circ_engine lpm_circ_engine_chk #(.MEM_AW(MEM_AW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .rsp_here(rsp_here), .rsp_leaf(rsp_leaf), .rob_full(rob_full),
  .fifo_cnt(fifo_cnt)
);

// File: tb/lpm_circ_engine_bench.sv
module lpm_circ_engine_bench;
  localparam int AW  = 18;
  localparam int LAT = 5;
  localparam int ROB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_result;
  logic mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [AW:0] mem_rsp_data;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] expq [$];

  always #2.5 clk = ~clk;

  lpm_circ_engine #(.MEM_AW(AW), .LAT(LAT), .ROB_DEPTH(ROB)) u_lpm_circ_engine (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_data(mem_rsp_data)
  );

  // table: explicit entries, otherwise a leaf of 0x10000 | low address bits
  logic [AW:0] tbl [int];
  function automatic logic [AW:0] mem_rd(input int a);
    if (tbl.exists(a)) return tbl[a];
    return {1'b1, 2'b01, a[15:0]};
  endfunction

  // fixed-latency memory model
  logic [AW-1:0] apipe [LAT];
  always @(posedge clk) begin
    apipe[0] <= mem_req_addr;
    for (int k = 1; k < LAT; k++) apipe[k] <= apipe[k-1];
  end
  always_comb mem_rsp_data = mem_rd(int'(apipe[LAT-1]));

  function automatic logic [AW-1:0] model(input logic [31:0] ip);
    logic [AW:0] e;
    e = mem_rd(int'(ip[31:16]));
    if (e[AW]) return e[AW-1:0];
    e = mem_rd(int'(e[AW-1:0] + AW'(ip[15:8])));
    if (e[AW]) return e[AW-1:0];
    e = mem_rd(int'(e[AW-1:0] + AW'(ip[7:0])));
    return e[AW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers one address, checks the first read (R1), records expectation
  task automatic send(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    check(mem_req_valid && mem_req_addr == AW'(a[31:16]), "R1 first read", 32'(mem_req_addr), 32'(a[31:16]));
    expq.push_back(model(a));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: scoreboard compare in order (R2, R4, R7)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 unexpected result", 32'(out_result), 32'h0);
        end else begin
          logic [AW-1:0] e;
          e = expq.pop_front();
          check(out_result == e, "R7 order/value", 32'(out_result), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    // three-level path: 0x0A07 -> ptr 0x20000; +0x0E -> ptr 0x20100
    tbl[32'h0A07]  = {1'b0, 18'h20000};
    tbl[32'h2000E] = {1'b0, 18'h20100};
    tbl[32'h20005] = {1'b1, 18'h3ABCD};   // leaf at level two
    tbl[32'h20107] = {1'b0, 18'h2BEEF};   // level three, flag clear: forced leaf (R4)

    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R11 mem_req_valid", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;

    // R2: single leaf
    send(32'h1234_5678);
    drain();

    // R3/R5: recirculating reads at ptr + byte
    send(32'h0A07_0E07);
    repeat (LAT - 1) @(negedge clk);
    #1;
    check(mem_req_valid && mem_req_addr == 18'h2000E, "R3 second read", 32'(mem_req_addr), 32'h2000E);
    check(in_ready == 1'b0, "R5 recirc blocks entry", 32'(in_ready), 32'd0);
    repeat (LAT) @(negedge clk);
    #1;
    check(mem_req_valid && mem_req_addr == 18'h20107, "R3 third read", 32'(mem_req_addr), 32'h20107);
    drain();   // R4: result 0x2BEEF checked by monitor

    // R6: entry in the cycle a leaf answer arrives
    send(32'h5555_0001);
    repeat (LAT - 1) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = 32'h6666_0002;
    #1;
    check(in_ready == 1'b1, "R6 entry beside leaf", 32'(in_ready), 32'd1);
    check(mem_req_valid && mem_req_addr == 18'h06666, "R6 entry read", 32'(mem_req_addr), 32'h06666);
    expq.push_back(model(32'h6666_0002));
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R7: three-read lookup overtaken by single reads
    send(32'h0A07_0E33);
    send(32'h0A07_0533);
    send(32'h7777_0000);
    send(32'h0102_0304);
    drain();

    // R8: hold under back-pressure
    out_ready = 1'b0;
    send(32'h4242_4242);
    while (!out_valid) @(negedge clk);
    held = out_result;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid && out_result == held, "R8 hold", 32'(out_result), 32'(held));
    out_ready = 1'b1;
    drain();

    // R9: reorder buffer full stalls entry
    out_ready = 1'b0;
    for (int i = 0; i < ROB; i++) send(32'h3000_0000 + 32'(i) * 32'h0001_0000);
    repeat (LAT + 2) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = 32'h3900_0000;
    #1;
    check(in_ready == 1'b0, "R9 full stall", 32'(in_ready), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    drain();

    // R10: clear with reads outstanding
    send(32'h0A07_0E07);
    send(32'h1111_2222);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    expq.delete();
    #1;
    check(out_valid == 1'b0, "R10 empty after clear", 32'(out_valid), 32'd0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 3 * LAT; i++) begin
        @(negedge clk);
        #1;
        if (out_valid) seen = 1'b1;
      end
      check(!seen, "R10 stale answers dropped", 32'(seen), 32'd0);
    end
    send(32'h0A07_0E10);
    send(32'h2222_3333);
    drain();

    // mixed traffic
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (i % 3 == 0) a[31:16] = 16'h0A07;
      if (i % 6 == 0) a[15:8]  = 8'h0E;
      send(a);
    end
    drain();
    check(expq.size() == 0, "R7 all delivered", 32'(expq.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule